// File: doc/BRIEF.md
# Directory Home Controller

This block is the home-node coherence controller for a shared memory used by a fixed set of processors. It keeps, for every memory block it is home to, a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. It also holds the backing data for those blocks. Caches send it read misses, write misses and data write backs. It answers with data replies and directs invalidations and owner fetches at the caches that hold copies.

Requests arrive on a valid/ready stream. The controller serves one request at a time. `req_ready` is high only when it is idle. It stays low from the cycle a request is accepted until the final outgoing message of that request has been taken. Outgoing messages leave on a second valid/ready stream. While `msg_valid` is high and `msg_ready` is low, the message fields are held unchanged. A sender may keep `req_valid` high for any number of cycles. The request is taken on the first edge where both `req_valid` and `req_ready` are high.

When a block is Exclusive, a miss from another processor first fetches the block from its owner. The owner returns the block on a dedicated write-back stream. `wb_ready` is high only while the controller waits for that data. Invalidations go out one per accepted handshake, in ascending processor index. The requester itself is never sent one.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and zero data. `req_ready` is 1, and `msg_valid` and `wb_ready` are 0.
- R2: A read miss (req_type 0) to an Uncached block produces exactly one data reply (msg_type 0) to the requester, carrying the stored data. The block becomes Shared with only the requester present.
- R3: A read miss to a Shared block produces only a data reply with the stored data. The requester is added to the presence vector and no other message is sent.
- R4: A write miss (req_type 1) to an Uncached block produces only a data reply to the requester. The block becomes Exclusive with the requester as the only present processor.
- R5: A write miss to a Shared block first sends an invalidate (msg_type 1) to each present processor other than the requester, in ascending index, one per handshake. It then sends a data reply to the requester and leaves the block Exclusive with only the requester present.
- R6: A read miss to an Exclusive block sends a fetch (msg_type 2) to the owner and waits on the write-back stream. The returned data is written to memory and replied to the requester. The block becomes Shared with both the owner and the requester present.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (msg_type 3) to the owner and waits for its data. The data is written to memory and replied to the requester. The block stays Exclusive with only the requester present.
- R8: A data write back (req_type 2) from the owner of an Exclusive block stores its data, makes the block Uncached with an empty vector, and sends no message.
- R9: A write back from a processor that is not the owner, a write back to a block that is not Exclusive, and request code 3 all send no message and change neither state nor data.
- R10: `req_ready` is low from acceptance until the last message of the request is taken. `wb_ready` is high only while awaiting owner data, and no message is offered during that wait.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_type`, `msg_dst`, `msg_addr` and `msg_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 data write back, 3 no operation |
| req_src | input | clog2(NPROC) | Requesting processor index |
| req_addr | input | clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Outgoing message taken |
| msg_type | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst | output | clog2(NPROC) | Destination processor |
| msg_addr | output | clog2(NBLK) | Block index of the message |
| msg_data | output | DW | Reply data (zero for other types) |
| wb_valid | input | 1 | Owner data offered after a fetch |
| wb_ready | output | 1 | Controller awaiting owner data |
| wb_data | input | DW | Owner data |

## Verification
The bench uses the default sizes: four processors, sixteen blocks and 16-bit data. With four processors, a block can be shared by every processor at once. A write miss from a middle index then shows the invalidate fan-out skipping the requester, with present bits on both sides of it. A previous owner that stays present after a fetch is invalidated in turn later. Each scenario works on its own block, so no scenario depends on state left by another. One scenario toggles the message ready every cycle to hold invalidates and replies under back-pressure.

// File: rtl/dir_pkg.sv
package dir_pkg;

  // Request codes on req_type
  localparam logic [1:0] REQ_RD   = 2'd0;
  localparam logic [1:0] REQ_WR   = 2'd1;
  localparam logic [1:0] REQ_WB   = 2'd2;

  // Message codes on msg_type
  localparam logic [1:0] MSG_DATA      = 2'd0;
  localparam logic [1:0] MSG_INV       = 2'd1;
  localparam logic [1:0] MSG_FETCH     = 2'd2;
  localparam logic [1:0] MSG_FETCH_INV = 2'd3;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_e;

  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_INV   = 3'd1,
    C_FETCH = 3'd2,
    C_WAIT  = 3'd3,
    C_REPLY = 3'd4
  } ctrl_e;

endpackage

// File: rtl/dir_entry_table.sv
module dir_entry_table
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NBLK)-1:0]  rd_addr,
  output dstate_e                  rd_state,
  output logic [NPROC-1:0]         rd_sharers,
  input  logic                     wr_en,
  input  logic [$clog2(NBLK)-1:0]  wr_addr,
  input  dstate_e                  wr_state,
  input  logic [NPROC-1:0]         wr_sharers
);

  dstate_e          st_arr [NBLK];
  logic [NPROC-1:0] sh_arr [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_arr[g] <= DS_UNC;
        sh_arr[g] <= '0;
      end else if (wr_en && (wr_addr == g[$clog2(NBLK)-1:0])) begin
        st_arr[g] <= wr_state;
        sh_arr[g] <= wr_sharers;
      end
    end
  end

  assign rd_state   = st_arr[rd_addr];
  assign rd_sharers = sh_arr[rd_addr];

endmodule

// File: rtl/dir_data_store.sv
module dir_data_store #(
  parameter int NBLK = 16,
  parameter int DW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NBLK)-1:0]  rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(NBLK)-1:0]  wr_addr,
  input  logic [DW-1:0]            wr_data
);

  logic [DW-1:0] words [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (wr_en && (wr_addr == g[$clog2(NBLK)-1:0])) begin
        words[g] <= wr_data;
      end
    end
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/dir_inv_scan.sv
module dir_inv_scan #(
  parameter int NPROC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NPROC-1:0]          load_mask,
  input  logic                      advance,
  output logic [$clog2(NPROC)-1:0]  cur_idx,
  output logic                      is_last
);

  localparam int PW = $clog2(NPROC);

  logic [NPROC-1:0] pend_q;
  logic [NPROC-1:0] low_oh;

  // lowest set bit of the pending mask
  assign low_oh  = pend_q & (~pend_q + NPROC'(1));
  assign is_last = (pend_q & ~low_oh) == '0;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NPROC; i++) begin
      if (low_oh[i]) cur_idx = PW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (load) begin
      pend_q <= load_mask;
    end else if (advance) begin
      pend_q <= pend_q & ~low_oh;
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_type,
  input  logic [$clog2(NPROC)-1:0]  req_src,
  input  logic [$clog2(NBLK)-1:0]   req_addr,
  input  logic [DW-1:0]             req_data,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [1:0]                msg_type,
  output logic [$clog2(NPROC)-1:0]  msg_dst,
  output logic [$clog2(NBLK)-1:0]   msg_addr,
  output logic [DW-1:0]             msg_data,
  input  logic                      wb_valid,
  output logic                      wb_ready,
  input  logic [DW-1:0]             wb_data
);

  localparam int PW = $clog2(NPROC);
  localparam int AW = $clog2(NBLK);

  ctrl_e            st_q, st_d;
  logic [1:0]       op_q;
  logic [PW-1:0]    src_q, own_q, own_idx;
  logic [AW-1:0]    addr_q, look_addr;
  logic [DW-1:0]    rep_q, rep_d;
  logic             cap_rep;

  dstate_e          ent_st;
  logic [NPROC-1:0] ent_sh;
  logic [DW-1:0]    mem_rd;
  logic [NPROC-1:0] req_oh, src_oh, pend_init;

  logic             tbl_we;
  dstate_e          tbl_wst;
  logic [NPROC-1:0] tbl_wsh;
  logic             mem_we;
  logic [AW-1:0]    mem_wa;
  logic [DW-1:0]    mem_wd;

  logic             ld_pend, adv_pend, scan_last;
  logic [PW-1:0]    scan_idx;
  logic             accept;

  assign look_addr = (st_q == C_IDLE) ? req_addr : addr_q;
  assign req_oh    = NPROC'(1) << req_src;
  assign src_oh    = NPROC'(1) << src_q;
  assign pend_init = ent_sh & ~req_oh;
  assign accept    = req_valid && (st_q == C_IDLE);

  // owner of an exclusive block: lowest present bit
  always_comb begin
    own_idx = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (ent_sh[i]) own_idx = PW'(i);
    end
  end

  dir_entry_table #(.NPROC(NPROC), .NBLK(NBLK)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr    (look_addr),
    .rd_state   (ent_st),
    .rd_sharers (ent_sh),
    .wr_en      (tbl_we),
    .wr_addr    (look_addr),
    .wr_state   (tbl_wst),
    .wr_sharers (tbl_wsh)
  );

  dir_data_store #(.NBLK(NBLK), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (look_addr),
    .rd_data (mem_rd),
    .wr_en   (mem_we),
    .wr_addr (mem_wa),
    .wr_data (mem_wd)
  );

  dir_inv_scan #(.NPROC(NPROC)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld_pend),
    .load_mask (pend_init),
    .advance   (adv_pend),
    .cur_idx   (scan_idx),
    .is_last   (scan_last)
  );

  // next-state, directory update and memory update
  always_comb begin
    st_d     = st_q;
    tbl_we   = 1'b0;
    tbl_wst  = DS_UNC;
    tbl_wsh  = '0;
    mem_we   = 1'b0;
    mem_wa   = addr_q;
    mem_wd   = wb_data;
    ld_pend  = 1'b0;
    adv_pend = 1'b0;
    cap_rep  = 1'b0;
    rep_d    = mem_rd;

    unique case (st_q)
      C_IDLE: begin
        if (accept) begin
          unique case (req_type)
            REQ_RD: begin
              if (ent_st == DS_EXC) begin
                st_d = C_FETCH;
              end else begin
                tbl_we  = 1'b1;
                tbl_wst = DS_SHR;
                tbl_wsh = ent_sh | req_oh;
                cap_rep = 1'b1;
                st_d    = C_REPLY;
              end
            end
            REQ_WR: begin
              if (ent_st == DS_EXC) begin
                st_d = C_FETCH;
              end else if ((ent_st == DS_SHR) && (pend_init != '0)) begin
                ld_pend = 1'b1;
                cap_rep = 1'b1;
                st_d    = C_INV;
              end else begin
                tbl_we  = 1'b1;
                tbl_wst = DS_EXC;
                tbl_wsh = req_oh;
                cap_rep = 1'b1;
                st_d    = C_REPLY;
              end
            end
            default: begin
              // write back: honoured only from the present owner
              if ((req_type == REQ_WB) && (ent_st == DS_EXC) &&
                  ((ent_sh & req_oh) != '0)) begin
                mem_we  = 1'b1;
                mem_wa  = req_addr;
                mem_wd  = req_data;
                tbl_we  = 1'b1;
                tbl_wst = DS_UNC;
                tbl_wsh = '0;
              end
            end
          endcase
        end
      end
      C_INV: begin
        if (msg_ready) begin
          adv_pend = 1'b1;
          if (scan_last) begin
            tbl_we  = 1'b1;
            tbl_wst = DS_EXC;
            tbl_wsh = src_oh;
            st_d    = C_REPLY;
          end
        end
      end
      C_FETCH: begin
        if (msg_ready) st_d = C_WAIT;
      end
      C_WAIT: begin
        if (wb_valid) begin
          mem_we  = 1'b1;
          mem_wd  = wb_data;
          cap_rep = 1'b1;
          rep_d   = wb_data;
          tbl_we  = 1'b1;
          if (op_q == REQ_RD) begin
            tbl_wst = DS_SHR;
            tbl_wsh = ent_sh | src_oh;
          end else begin
            tbl_wst = DS_EXC;
            tbl_wsh = src_oh;
          end
          st_d = C_REPLY;
        end
      end
      C_REPLY: begin
        if (msg_ready) st_d = C_IDLE;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      op_q   <= REQ_RD;
      src_q  <= '0;
      own_q  <= '0;
      addr_q <= '0;
      rep_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q   <= req_type;
        src_q  <= req_src;
        addr_q <= req_addr;
        own_q  <= own_idx;
      end
      if (cap_rep) rep_q <= rep_d;
    end
  end

  // stream outputs
  assign req_ready = (st_q == C_IDLE);
  assign wb_ready  = (st_q == C_WAIT);
  assign msg_valid = (st_q == C_INV) || (st_q == C_FETCH) || (st_q == C_REPLY);
  assign msg_addr  = addr_q;
  assign msg_data  = (st_q == C_REPLY) ? rep_q : '0;

  always_comb begin
    unique case (st_q)
      C_INV: begin
        msg_type = MSG_INV;
        msg_dst  = scan_idx;
      end
      C_FETCH: begin
        msg_type = (op_q == REQ_RD) ? MSG_FETCH : MSG_FETCH_INV;
        msg_dst  = own_q;
      end
      default: begin
        msg_type = MSG_DATA;
        msg_dst  = src_q;
      end
    endcase
  end

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_ready,
  input logic                      msg_valid,
  input logic                      msg_ready,
  input logic [1:0]                msg_type,
  input logic [$clog2(NPROC)-1:0]  msg_dst,
  input logic [$clog2(NBLK)-1:0]   msg_addr,
  input logic [DW-1:0]             msg_data,
  input logic                      wb_ready
);

  AST_BUSY_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);  // R10

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ready |-> (!req_ready && !msg_valid));  // R10

  AST_REPLY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_type == 2'd0) |=> req_ready);  // R10

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_dst)
                                   && $stable(msg_addr) && $stable(msg_data)));  // R11

  AST_INV_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_type == 2'd1) |=>
      (!(msg_valid && msg_type == 2'd1) || (msg_dst > $past(msg_dst))));  // R5

  AST_FETCH_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_type[1]) |=> wb_ready);  // R6

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_type  (msg_type),
  .msg_dst   (msg_dst),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .wb_ready  (wb_ready)
);

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_type = 2'd0;
  logic [1:0]  req_src = 2'd0;
  logic [3:0]  req_addr = 4'd0;
  logic [15:0] req_data = 16'd0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [1:0]  msg_type;
  logic [1:0]  msg_dst;
  logic [3:0]  msg_addr;
  logic [15:0] msg_data;
  logic        wb_valid = 1'b0;
  logic        wb_ready;
  logic [15:0] wb_data = 16'd0;

  always #4 clk = ~clk;  // 125 MHz

  dir_home_ctrl #(.NPROC(4), .NBLK(16), .DW(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data)
  );

  int checks = 0;
  int failures = 0;
  int n_msg;
  int m_typ [16];
  int m_dst [16];
  int m_dat [16];
  int m_adr [16];
  int cur_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_count(input int n, input string tag);
    chk(n_msg == n, tag, "message count", n_msg, n);
  endtask

  // packed compare: type, dst, addr, data
  task automatic expect_msg(input int i, input int typ, input int dst,
                            input int dat, input string tag);
    int act, exp;
    act = (m_typ[i] << 28) | (m_dst[i] << 24) | (m_adr[i] << 16) | m_dat[i];
    exp = (typ << 28) | (dst << 24) | (cur_addr << 16) | dat;
    chk(i < n_msg && act == exp, tag, $sformatf("message %0d t/d/a/data", i), act, exp);
  endtask

  // One request, carried to completion; owner data wbd returned after any fetch.
  task automatic run(input logic [1:0] typ, input int src, input int addr,
                     input int d, input int wbd, input bit stall, input string tag);
    bit accepted = 0, done = 0, fetch_seen = 0, wb_given = 0, wait_chk = 0;
    bit held = 0;
    int hold_val = 0;
    n_msg = 0;
    cur_addr = addr;
    @(posedge clk); #1;
    req_valid = 1'b1; req_type = typ; req_src = 2'(src);
    req_addr = 4'(addr); req_data = 16'(d);
    msg_ready = stall ? 1'b0 : 1'b1;
    for (int i = 0; i < 200 && !done; i++) begin
      bit acc_now, wb_now;
      @(negedge clk);
      if (held) begin
        chk(msg_valid && hold_val == {msg_type, msg_dst, msg_addr, msg_data}, "R11",
            "payload held under stall", {msg_type, msg_dst, msg_addr, msg_data}, hold_val);
      end
      held = msg_valid && !msg_ready;
      hold_val = {msg_type, msg_dst, msg_addr, msg_data};
      if (msg_valid && msg_ready && n_msg < 16) begin
        m_typ[n_msg] = msg_type; m_dst[n_msg] = msg_dst;
        m_adr[n_msg] = msg_addr; m_dat[n_msg] = msg_data;
        n_msg++;
        if (msg_type[1]) fetch_seen = 1;
      end
      if (wb_ready && !wait_chk) begin
        wait_chk = 1;
        chk(!req_ready && !msg_valid, "R10", "busy and quiet while awaiting owner",
            {req_ready, msg_valid}, 0);
      end
      if (accepted && req_ready && !req_valid) done = 1;
      acc_now = req_valid && req_ready;
      wb_now  = wb_valid && wb_ready;
      if (!done) begin
        @(posedge clk); #1;
        if (acc_now) begin req_valid = 1'b0; accepted = 1; end
        if (wb_now) wb_valid = 1'b0;
        else if (fetch_seen && !wb_given) begin
          wb_valid = 1'b1; wb_data = 16'(wbd); wb_given = 1;
        end
        msg_ready = stall ? ~msg_ready : 1'b1;
      end
    end
    chk(done, tag, "request completed", done, 1);
    msg_ready = 1'b1;
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
    chk(wb_ready == 1'b0, "R1", "wb_ready after reset", wb_ready, 0);
  endtask

  task automatic t_read_sharing;
    run(2'd0, 0, 1, 0, 0, 0, "R2");
    expect_count(1, "R2"); expect_msg(0, 0, 0, 16'h0000, "R2");
    run(2'd0, 2, 1, 0, 0, 0, "R3");
    expect_count(1, "R3"); expect_msg(0, 0, 2, 16'h0000, "R3");
  endtask

  task automatic t_owner_fetch;
    run(2'd1, 1, 2, 0, 0, 0, "R4");
    expect_count(1, "R4"); expect_msg(0, 0, 1, 0, "R4");
    run(2'd0, 3, 2, 0, 16'hA5A5, 0, "R6");
    expect_count(2, "R6"); expect_msg(0, 2, 1, 0, "R6"); expect_msg(1, 0, 3, 16'hA5A5, "R6");
    run(2'd0, 2, 2, 0, 0, 0, "R6");
    expect_count(1, "R6"); expect_msg(0, 0, 2, 16'hA5A5, "R6");
    // owner 1 stayed present: 1,2,3 all invalidated
    run(2'd1, 0, 2, 0, 0, 0, "R5");
    expect_count(4, "R5");
    expect_msg(0, 1, 1, 0, "R5"); expect_msg(1, 1, 2, 0, "R5");
    expect_msg(2, 1, 3, 0, "R5"); expect_msg(3, 0, 0, 16'hA5A5, "R5");
  endtask

  task automatic t_fanout_stall;
    for (int p = 0; p < 4; p++) run(2'd0, p, 3, 0, 0, 0, "R3");
    expect_count(1, "R3"); expect_msg(0, 0, 3, 0, "R3");
    run(2'd1, 2, 3, 0, 0, 1, "R5");
    expect_count(4, "R5");
    expect_msg(0, 1, 0, 0, "R5"); expect_msg(1, 1, 1, 0, "R5");
    expect_msg(2, 1, 3, 0, "R5"); expect_msg(3, 0, 2, 0, "R5");
  endtask

  task automatic t_write_steal;
    run(2'd1, 3, 4, 0, 0, 0, "R4");
    expect_count(1, "R4");
    run(2'd1, 0, 4, 0, 16'h1234, 0, "R7");
    expect_count(2, "R7"); expect_msg(0, 3, 3, 0, "R7"); expect_msg(1, 0, 0, 16'h1234, "R7");
    run(2'd0, 1, 4, 0, 16'h5678, 0, "R7");
    expect_count(2, "R7"); expect_msg(0, 2, 0, 0, "R7"); expect_msg(1, 0, 1, 16'h5678, "R7");
  endtask

  task automatic t_writeback;
    run(2'd1, 2, 5, 0, 0, 0, "R4");
    run(2'd2, 1, 5, 16'hDEAD, 0, 0, "R9");
    expect_count(0, "R9");
    run(2'd3, 2, 5, 16'hCAFE, 0, 0, "R9");
    expect_count(0, "R9");
    run(2'd2, 2, 5, 16'hBEEF, 0, 0, "R8");
    expect_count(0, "R8");
    run(2'd0, 0, 5, 0, 0, 0, "R8");
    expect_count(1, "R8"); expect_msg(0, 0, 0, 16'hBEEF, "R8");
    run(2'd2, 0, 5, 16'h1111, 0, 0, "R9");
    expect_count(0, "R9");
    run(2'd0, 1, 5, 0, 0, 0, "R9");
    expect_count(1, "R9"); expect_msg(0, 0, 1, 16'hBEEF, "R9");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_sharing;
    t_owner_fetch;
    t_fanout_stall;
    t_write_steal;
    t_writeback;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule